// File: doc/BRIEF.md
# Write-Protection Sequence Detector

This block sits between the host write port and the write controller of a byte-wide non-volatile memory. It watches every bus write for short command sequences, written to two fixed addresses, that switch a protection flag on or off. While protection is on, a data write reaches the array only when the three-write unlock command comes directly before it. A write that is blocked still starts a timed program cycle, but no data is stored. Command writes are absorbed and never stored, but the same addresses take user data as normal whenever the data byte does not match.

For each write strobe the block answers one clock later with exactly one of three pulses: commit the byte, run a dummy timed cycle, or drop the write as a command. The protection flag models non-volatile storage. It starts cleared, as on a new part. A completed command changes it only after one program-cycle time. Reset clears the detector and drops an unfinished flag change, but it never clears the flag itself.

Top module: `wp_guard`

## Requirements
- R1: While reset is high, and on the first cycle after it, no action output is asserted. `protect_on` is 0 on a fresh start.
- R2: A write strobe in the cycle that ends at a clock edge gives exactly one of `go_commit`, `go_dummy`, `cmd_eaten` high for the cycle after that edge. Without a strobe, all three stay low.
- R3: With protection off and no command in progress, an ordinary write asserts `go_commit`.
- R4: The enable command is three writes: data 8'hAA to address 13'h1555, then 8'h55 to 13'h0AAA, then 8'hA0 to 13'h1555. Each of these writes asserts `cmd_eaten`. `protect_on` rises WC_CYCLES clock edges after the edge that took the last of them, and not before.
- R5: With protection on and no unlock in effect, an ordinary write asserts `go_dummy`.
- R6: After the enable command, every following write asserts `go_commit` while each one arrives within LOAD_TIMEOUT cycles of the previous write. A gap longer than LOAD_TIMEOUT closes this window.
- R7: The disable command is six writes: 8'hAA@13'h1555, 8'h55@13'h0AAA, 8'h80@13'h1555, 8'hAA@13'h1555, 8'h55@13'h0AAA, 8'h20@13'h1555. Each of these writes asserts `cmd_eaten`. `protect_on` falls WC_CYCLES edges after the last one, and plain writes then commit.
- R8: A partly entered command is accepted when the gap between two of its writes is exactly LOAD_TIMEOUT cycles. A gap longer than that returns the detector to idle, and the remaining command writes are then treated as data.
- R9: A write that breaks a command part-way is handled as ordinary data, and the detector returns to idle.
- R10: Reset leaves `protect_on` unchanged and cancels a flag change that is still waiting out its program-cycle time.
- R11: A write to a command address whose data byte does not begin a command is ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One write is presented in this cycle |
| wr_addr | input | 13 | Write address |
| wr_data | input | 8 | Write data byte |
| go_commit | output | 1 | Store the previous cycle's write |
| go_dummy | output | 1 | Run a timed cycle without storing |
| cmd_eaten | output | 1 | Previous write was absorbed as a command |
| protect_on | output | 1 | Current protection flag |

## Verification
A detector left in the wrong state shows up on the very next write. That write gets the wrong pulse: data is absorbed as a command, a prefixed write is blocked, or an unprefixed one is committed. A wrong flag state or wrong pending timer is seen at `protect_on` on the exact edge where a change is due. The bench samples one edge early and on the exact edge. A stuck timeout counter is seen as a command write that is accepted after too long a gap, or dropped after exactly LOAD_TIMEOUT cycles.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] KEY_ADDR_A = 13'h1555;
    localparam logic [ADDR_W-1:0] KEY_ADDR_B = 13'h0AAA;
    localparam logic [DATA_W-1:0] KEY_LEAD   = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_FOLLOW = 8'h55;
    localparam logic [DATA_W-1:0] KEY_ARM    = 8'hA0;
    localparam logic [DATA_W-1:0] KEY_ERASE  = 8'h80;
    localparam logic [DATA_W-1:0] KEY_DISARM = 8'h20;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_U1, ST_U2, ST_OPEN, ST_D3, ST_D4, ST_D5
    } seq_state_e;

    typedef enum logic [1:0] {
        ACT_NONE, ACT_COMMIT, ACT_DUMMY, ACT_CONSUME
    } wr_action_e;

    function automatic logic is_key(bus_wr_t w, logic [ADDR_W-1:0] a,
                                    logic [DATA_W-1:0] d);
        return (w.addr == a) && (w.data == d);
    endfunction

endpackage

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm
    import wp_pkg::*;
#(
    parameter int LOAD_TO = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_stb,
    input  bus_wr_t    wr,
    input  logic       prot,
    output wr_action_e act_q,
    output logic       en_req,
    output logic       dis_req
);

    localparam int CW = (LOAD_TO > 2) ? $clog2(LOAD_TO) : 1;
    localparam logic [CW-1:0] GAP_LAST = CW'(LOAD_TO - 1);

    seq_state_e st_q, st_d;
    logic [CW-1:0] gap_q;
    wr_action_e act_d, data_act;

    always_comb begin
        st_d     = st_q;
        act_d    = ACT_NONE;
        en_req   = 1'b0;
        dis_req  = 1'b0;
        data_act = prot ? ACT_DUMMY : ACT_COMMIT;
        if (wr_stb) begin
            act_d = data_act;
            st_d  = ST_IDLE;
            unique case (st_q)
                ST_IDLE: if (is_key(wr, KEY_ADDR_A, KEY_LEAD)) begin
                    st_d = ST_U1; act_d = ACT_CONSUME;
                end
                ST_U1: if (is_key(wr, KEY_ADDR_B, KEY_FOLLOW)) begin
                    st_d = ST_U2; act_d = ACT_CONSUME;
                end
                ST_U2: if (is_key(wr, KEY_ADDR_A, KEY_ARM)) begin
                    st_d = ST_OPEN; act_d = ACT_CONSUME; en_req = 1'b1;
                end else if (is_key(wr, KEY_ADDR_A, KEY_ERASE)) begin
                    st_d = ST_D3; act_d = ACT_CONSUME;
                end
                ST_OPEN: begin
                    st_d = ST_OPEN; act_d = ACT_COMMIT;
                end
                ST_D3: if (is_key(wr, KEY_ADDR_A, KEY_LEAD)) begin
                    st_d = ST_D4; act_d = ACT_CONSUME;
                end
                ST_D4: if (is_key(wr, KEY_ADDR_B, KEY_FOLLOW)) begin
                    st_d = ST_D5; act_d = ACT_CONSUME;
                end
                ST_D5: if (is_key(wr, KEY_ADDR_A, KEY_DISARM)) begin
                    act_d = ACT_CONSUME; dis_req = 1'b1;
                end
                default: ;
            endcase
        end else if (st_q != ST_IDLE && gap_q == GAP_LAST) begin
            st_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            gap_q <= '0;
            act_q <= ACT_NONE;
        end else begin
            st_q  <= st_d;
            act_q <= act_d;
            if (wr_stb)
                gap_q <= '0;
            else if (gap_q != GAP_LAST)
                gap_q <= gap_q + 1'b1;
        end
    end

    p_timeout_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && !wr_stb && gap_q == GAP_LAST) |=> st_q == ST_IDLE);

    p_open_commit_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OPEN && wr_stb) |=> act_q == ACT_COMMIT);

    p_blocked_dummy_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && wr_stb && prot && !is_key(wr, KEY_ADDR_A, KEY_LEAD))
        |=> act_q == ACT_DUMMY);

    p_single_req_r4: assert property (@(posedge clk) disable iff (rst)
        !(en_req && dis_req));

endmodule

// File: rtl/wp_nv_flag.sv
module wp_nv_flag #(
    parameter int WC_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic prot
);

    localparam int TW = $clog2(WC_CYCLES + 1);
    localparam logic [TW-1:0] LOAD_VAL = TW'(WC_CYCLES - 1);

    logic          flag_q = 1'b0;
    logic          pend_q;
    logic          val_q;
    logic [TW-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            val_q  <= 1'b0;
            tmr_q  <= '0;
        end else if (set_req || clr_req) begin
            pend_q <= 1'b1;
            val_q  <= set_req;
            tmr_q  <= LOAD_VAL;
        end else if (pend_q) begin
            if (tmr_q == '0) begin
                flag_q <= val_q;
                pend_q <= 1'b0;
            end else begin
                tmr_q <= tmr_q - 1'b1;
            end
        end
    end

    assign prot = flag_q;

    p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !pend_q |=> $stable(flag_q));

    p_flag_apply_r7: assert property (@(posedge clk) disable iff (rst)
        (pend_q && tmr_q == '0 && !set_req && !clr_req) |=> flag_q == $past(val_q));

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_pkg::*;
#(
    parameter int LOAD_TIMEOUT = 16,
    parameter int WC_CYCLES    = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              go_commit,
    output logic              go_dummy,
    output logic              cmd_eaten,
    output logic              protect_on
);

    bus_wr_t    wr;
    wr_action_e act;
    logic       en_req, dis_req;

    assign wr.addr = wr_addr;
    assign wr.data = wr_data;

    wp_seq_fsm #(.LOAD_TO(LOAD_TIMEOUT)) u_fsm (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr(wr), .prot(protect_on),
        .act_q(act), .en_req(en_req), .dis_req(dis_req)
    );

    wp_nv_flag #(.WC_CYCLES(WC_CYCLES)) u_flag (
        .clk(clk), .rst(rst), .set_req(en_req), .clr_req(dis_req),
        .prot(protect_on)
    );

    assign go_commit = (act == ACT_COMMIT);
    assign go_dummy  = (act == ACT_DUMMY);
    assign cmd_eaten = (act == ACT_CONSUME);

    p_act_onehot_r2: assert property (@(posedge clk)
        $onehot0({go_commit, go_dummy, cmd_eaten}));

    p_stb_act_r2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> $countones({go_commit, go_dummy, cmd_eaten}) == 1);

    p_idle_act_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> !(go_commit || go_dummy || cmd_eaten));

endmodule

// File: tb/wp_guard_tb_top.sv
`timescale 1ns/1ps
module wp_guard_tb_top;

    localparam int LT   = 16;
    localparam int WC   = 48;
    localparam int NONE = 0, COMMIT = 1, DUMMY = 2, CONS = 3;

    logic        clk = 1'b0, rst = 1'b1, wr_stb = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        go_commit, go_dummy, cmd_eaten, protect_on;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    wp_guard #(.LOAD_TIMEOUT(LT), .WC_CYCLES(WC)) dut_i (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .go_commit(go_commit), .go_dummy(go_dummy),
        .cmd_eaten(cmd_eaten), .protect_on(protect_on)
    );

    always #5 clk = ~clk;

    function automatic int act_code();
        if ($countones({go_commit, go_dummy, cmd_eaten}) > 1) return 9;
        if (go_commit) return COMMIT;
        if (go_dummy)  return DUMMY;
        if (cmd_eaten) return CONS;
        return NONE;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic gap(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [12:0] a, logic [7:0] d, int exp, string req);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(req, act_code(), exp);
    endtask

    task automatic rand_writes(int n, int exp, string req);
        for (int i = 0; i < n; i++) begin
            logic [12:0] a = 13'($urandom % 8192);
            logic [7:0]  d = 8'($urandom % 256);
            if (a == 13'h1555 && d == 8'hAA) d = 8'h00;
            wr(a, d, exp, req);
            gap(int'($urandom % 4));
        end
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        gap(3);
        chk("R1", act_code(), NONE);
        chk("R1", int'(protect_on), 0);
        rst = 1'b0;
        gap(1);
        chk("R1", act_code(), NONE);

        // R11 / R3: command addresses with other data, ordinary writes
        wr(13'h1555, 8'h12, COMMIT, "R11");
        wr(13'h0AAA, 8'h55, COMMIT, "R11");
        wr(13'h0100, 8'h3C, COMMIT, "R3");
        gap(2);
        chk("R2", act_code(), NONE);
        rand_writes(40, COMMIT, "R3");
        gap(LT + 1);

        // R4: enable command, window write, flag timing
        wr(13'h1555, 8'hAA, CONS, "R4");
        wr(13'h0AAA, 8'h55, CONS, "R4");
        wr(13'h1555, 8'hA0, CONS, "R4");
        wr(13'h0200, 8'h11, COMMIT, "R6");
        gap(WC - 2);
        chk("R4", int'(protect_on), 0);
        gap(1);
        chk("R4", int'(protect_on), 1);

        // R5: blocked writes
        wr(13'h0200, 8'h22, DUMMY, "R5");
        rand_writes(30, DUMMY, "R5");
        gap(LT + 1);

        // R6: prefixed page load, exact-limit gap, then window closes
        wr(13'h1555, 8'hAA, CONS, "R6");
        wr(13'h0AAA, 8'h55, CONS, "R6");
        wr(13'h1555, 8'hA0, CONS, "R6");
        gap(LT - 1);
        wr(13'h0210, 8'h5A, COMMIT, "R6");
        wr(13'h0211, 8'h5B, COMMIT, "R6");
        gap(LT);
        wr(13'h0212, 8'h5C, DUMMY, "R6");

        // R8: timeout mid-command
        gap(LT + 1);
        wr(13'h1555, 8'hAA, CONS, "R8");
        wr(13'h0AAA, 8'h55, CONS, "R8");
        gap(LT);
        wr(13'h1555, 8'hA0, DUMMY, "R8");
        wr(13'h0300, 8'h33, DUMMY, "R8");

        // R9: broken command
        wr(13'h1555, 8'hAA, CONS, "R9");
        wr(13'h0AAA, 8'h66, DUMMY, "R9");
        wr(13'h1555, 8'hA0, DUMMY, "R9");
        wr(13'h1555, 8'hAA, CONS, "R9");
        wr(13'h0AAA, 8'h55, CONS, "R9");
        wr(13'h1555, 8'h80, CONS, "R9");
        wr(13'h1555, 8'hBB, DUMMY, "R9");

        // R10: reset keeps flag and cancels pending change
        rst = 1'b1; gap(2); rst = 1'b0; gap(1);
        chk("R10", int'(protect_on), 1);
        wr(13'h1555, 8'hAA, CONS, "R7");
        wr(13'h0AAA, 8'h55, CONS, "R7");
        wr(13'h1555, 8'h80, CONS, "R7");
        wr(13'h1555, 8'hAA, CONS, "R7");
        wr(13'h0AAA, 8'h55, CONS, "R7");
        wr(13'h1555, 8'h20, CONS, "R7");
        gap(5);
        rst = 1'b1; gap(1); rst = 1'b0;
        gap(WC + 5);
        chk("R10", int'(protect_on), 1);

        // R7: full disable
        wr(13'h1555, 8'hAA, CONS, "R7");
        wr(13'h0AAA, 8'h55, CONS, "R7");
        wr(13'h1555, 8'h80, CONS, "R7");
        wr(13'h1555, 8'hAA, CONS, "R7");
        wr(13'h0AAA, 8'h55, CONS, "R7");
        wr(13'h1555, 8'h20, CONS, "R7");
        gap(WC - 1);
        chk("R7", int'(protect_on), 1);
        gap(1);
        chk("R7", int'(protect_on), 0);
        wr(13'h0400, 8'h44, COMMIT, "R7");
        rand_writes(10, COMMIT, "R3");
        gap(LT + 1);

        // R8: exact LOAD_TIMEOUT gaps inside a command are accepted
        wr(13'h1555, 8'hAA, CONS, "R8");
        gap(LT - 1);
        wr(13'h0AAA, 8'h55, CONS, "R8");
        gap(LT - 1);
        wr(13'h1555, 8'hA0, CONS, "R8");
        gap(WC + 2);
        chk("R8", int'(protect_on), 1);

        done = 1'b1;
        report();
        $finish;
    end

endmodule